// File: doc/BRIEF.md
# Frame Field Decoder for a Serial Link Receiver

This block sits behind the deserializer of a serial link receiver. Each clock it takes one parallel frame: a data field 20 or 16 bits wide, a 4-bit control field and a flag bit. It sorts the frame into one of three kinds: a data word, a control word or an idle fill word. It then rebuilds the payload. Words sent inverted are flipped back. A control word is packed down into contiguous low output bits, because two of its bits are taken up by the code.

Error and flag outputs depend on a flag-mode input. In one mode the flag bit is carried as an extra payload bit. In the other mode the flag bit is expected to alternate on successive data words, and a break in that pattern is reported as an error. All outputs are registered, so results appear one clock after the frame is presented.

Top module: `sfd_top`

## Requirements
- R1: The frame kind comes from the control field `in_ctrl` together with the two centre data bits, written as {hi,lo}. Code 0011 is a true data word and 1100 is an inverted data word, whatever the centre bits are. Code 0101 with {hi,lo}=10 is a true control word, and with 01 it is fill. Code 1010 with {hi,lo}=01 is an inverted control word, and with 10 it is fill. A data word sets `out_dav`, a control word sets `out_cav`, and fill leaves both at 0. The two strobes are never 1 together.
- R2: The centre bits are lo=bit 9 and hi=bit 10 when `wide_sel`=1 (20-bit field), and lo=bit 7 and hi=bit 8 when `wide_sel`=0 (16-bit field).
- R3: For an inverted data word or an inverted control word, every bit of the active field is complemented before any further processing.
- R4: For a control word, the field bits below and above the two centre bits are packed together. The lower part lands in the lowest output bits and the upper part sits directly above it. The result fills bits 17..0 in 20-bit mode and bits 13..0 in 16-bit mode. All higher output bits are 0.
- R5: In 16-bit mode, input bits 19..16 are ignored and output bits 19..16 are 0. A data word's active field is passed to `out_data` unchanged, apart from the R3 inversion.
- R6: Any combination not listed in R1 is illegal. It sets `out_err` to 1, holds both strobes at 0 and drives `out_data` to 0. Fill words also drive `out_data` to 0.
- R7: When `flag_sel`=1, `out_flag` copies `in_flag` for every valid frame, and `out_err` is 1 only for illegal codes.
- R8: When `flag_sel`=0, `out_flag` copies `in_flag` on data words and is 0 on fill, control and illegal frames.
- R9: When `flag_sel`=0, the block tracks the flag value it expects next, starting at 0 after reset. A data word whose flag differs from the expected value sets `out_err`, while `out_dav` and the payload stay as for a normal data word. After every data word the expected value becomes the inverse of the flag just received. Other frames, and all frames seen while `flag_sel`=1, leave the expected value unchanged.
- R10: A clock with `in_valid`=0 drives all outputs to 0 on the next cycle and does not change the tracked flag value.
- R11: Outputs reflect the frame presented one clock earlier. The synchronous active-high `rst` clears all outputs and the tracked flag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_sel | input | 1 | 1: 20-bit data field, 0: 16-bit data field |
| flag_sel | input | 1 | 1: flag is a payload bit, 0: flag must alternate |
| in_valid | input | 1 | Frame present this cycle |
| in_ctrl | input | 4 | Control field of the frame |
| in_data | input | 20 | Data field of the frame |
| in_flag | input | 1 | Flag bit of the frame |
| out_data | output | 20 | Restored payload |
| out_dav | output | 1 | Data word strobe |
| out_cav | output | 1 | Control word strobe |
| out_err | output | 1 | Illegal code or flag alternation break |
| out_flag | output | 1 | Flag output |

## Verification
Word restoration and flag tracking can act on the same frame. An inverted data word may also break the flag alternation, and the block must then complement the payload, raise `out_dav` and set `out_err`, all in one output cycle. The sweep provokes this by crossing every control code and centre-bit pair with frames whose flag is deliberately flipped against the tracked value. A bench-side model of the alternation predicts, frame by frame, both the restored word and the error bit. Both values are compared in the same sampled cycle.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    FT_FILL,
    FT_DATA,
    FT_DATA_INV,
    FT_CTRL,
    FT_CTRL_INV,
    FT_BAD
  } ftype_e;

  localparam logic [CODE_W-1:0] CODE_DATA     = 4'b0011;
  localparam logic [CODE_W-1:0] CODE_DATA_INV = 4'b1100;
  localparam logic [CODE_W-1:0] CODE_CTRL     = 4'b0101;
  localparam logic [CODE_W-1:0] CODE_CTRL_INV = 4'b1010;
endpackage

// File: rtl/sfd_classify.sv
module sfd_classify
  import sfd_pkg::*;
#(
  parameter int W_WIDE   = 20,
  parameter int W_NARROW = 16
) (
  input  logic              wide_sel,
  input  logic [CODE_W-1:0] ctrl,
  input  logic [W_WIDE-1:0] data,
  output ftype_e            ftype
);
  localparam int WLO = W_WIDE / 2 - 1;
  localparam int WHI = W_WIDE / 2;
  localparam int NLO = W_NARROW / 2 - 1;
  localparam int NHI = W_NARROW / 2;

  logic [1:0] ctr;

  always_comb begin
    ctr = wide_sel ? {data[WHI], data[WLO]} : {data[NHI], data[NLO]};
    case (ctrl)
      CODE_DATA:     ftype = FT_DATA;
      CODE_DATA_INV: ftype = FT_DATA_INV;
      CODE_CTRL:     ftype = (ctr == 2'b10) ? FT_CTRL :
                             (ctr == 2'b01) ? FT_FILL : FT_BAD;
      CODE_CTRL_INV: ftype = (ctr == 2'b01) ? FT_CTRL_INV :
                             (ctr == 2'b10) ? FT_FILL : FT_BAD;
      default:       ftype = FT_BAD;
    endcase
  end
endmodule

// File: rtl/sfd_restore.sv
module sfd_restore
  import sfd_pkg::*;
#(
  parameter int W_WIDE   = 20,
  parameter int W_NARROW = 16
) (
  input  logic              wide_sel,
  input  ftype_e            ftype,
  input  logic [W_WIDE-1:0] data,
  output logic [W_WIDE-1:0] payload
);
  localparam int WH = W_WIDE / 2;
  localparam int NH = W_NARROW / 2;
  localparam int WP = W_WIDE - 2;
  localparam int NP = W_NARROW - 2;

  logic [W_WIDE-1:0] fld;
  logic [W_WIDE-1:0] wpack;
  logic [W_WIDE-1:0] npack;
  logic              inv;

  assign inv = (ftype == FT_DATA_INV) || (ftype == FT_CTRL_INV);

  always_comb begin
    fld = '0;
    if (wide_sel) fld = data;
    else          fld[W_NARROW-1:0] = data[W_NARROW-1:0];
    if (inv) begin
      fld = ~fld;
      if (!wide_sel) fld[W_WIDE-1:W_NARROW] = '0;
    end
  end

  always_comb begin
    wpack = '0;
    npack = '0;
    wpack[WP-1:0] = {fld[W_WIDE-1:WH+1], fld[WH-2:0]};
    npack[NP-1:0] = {fld[W_NARROW-1:NH+1], fld[NH-2:0]};
  end

  always_comb begin
    case (ftype)
      FT_DATA, FT_DATA_INV: payload = fld;
      FT_CTRL, FT_CTRL_INV: payload = wide_sel ? wpack : npack;
      default:              payload = '0;
    endcase
  end
endmodule

// File: rtl/sfd_flagtrk.sv
module sfd_flagtrk (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic rx_flag,
  output logic mism
);
  logic exp_q;

  assign mism = upd && (rx_flag != exp_q);

  always_ff @(posedge clk) begin
    if (rst)      exp_q <= 1'b0;
    else if (upd) exp_q <= ~rx_flag;
  end

  // R9
  track_update_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> (exp_q == !$past(rx_flag)));

  // R9
  track_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(exp_q));
endmodule

// File: rtl/sfd_top.sv
module sfd_top
  import sfd_pkg::*;
#(
  parameter int W_WIDE   = 20,
  parameter int W_NARROW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_sel,
  input  logic              flag_sel,
  input  logic              in_valid,
  input  logic [3:0]        in_ctrl,
  input  logic [W_WIDE-1:0] in_data,
  input  logic              in_flag,
  output logic [W_WIDE-1:0] out_data,
  output logic              out_dav,
  output logic              out_cav,
  output logic              out_err,
  output logic              out_flag
);
  ftype_e            ftype;
  logic [W_WIDE-1:0] payload;
  logic              is_data;
  logic              is_ctrl;
  logic              is_bad;
  logic              upd;
  logic              mism;

  sfd_classify #(.W_WIDE(W_WIDE), .W_NARROW(W_NARROW)) u_classify (
    .wide_sel (wide_sel),
    .ctrl     (in_ctrl),
    .data     (in_data),
    .ftype    (ftype)
  );

  sfd_restore #(.W_WIDE(W_WIDE), .W_NARROW(W_NARROW)) u_restore (
    .wide_sel (wide_sel),
    .ftype    (ftype),
    .data     (in_data),
    .payload  (payload)
  );

  assign is_data = (ftype == FT_DATA) || (ftype == FT_DATA_INV);
  assign is_ctrl = (ftype == FT_CTRL) || (ftype == FT_CTRL_INV);
  assign is_bad  = (ftype == FT_BAD);
  assign upd     = in_valid && !flag_sel && is_data;

  sfd_flagtrk u_flagtrk (
    .clk     (clk),
    .rst     (rst),
    .upd     (upd),
    .rx_flag (in_flag),
    .mism    (mism)
  );

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_data <= '0;
      out_dav  <= 1'b0;
      out_cav  <= 1'b0;
      out_err  <= 1'b0;
      out_flag <= 1'b0;
    end else begin
      out_data <= payload;
      out_dav  <= is_data;
      out_cav  <= is_ctrl;
      if (flag_sel) begin
        out_err  <= is_bad;
        out_flag <= in_flag;
      end else begin
        out_err  <= is_bad || mism;
        out_flag <= is_data ? in_flag : 1'b0;
      end
    end
  end

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_dav && out_cav));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> (!out_dav && !out_cav && !out_err && !out_flag));

  // R4
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_cav |-> (out_data[W_WIDE-1:W_WIDE-2] == '0));

  // R6
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    (out_err && !out_dav) |-> (!out_cav && out_data == '0));

  // R8
  fill_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!flag_sel && in_valid) && !out_dav) |-> !out_flag);
endmodule

// File: tb/test_sfd_top.sv
`timescale 1ns/1ps
module test_sfd_top;
  localparam real CLK_NS = 4.0;

  logic        clk = 1'b0;
  logic        rst;
  logic        wide_sel, flag_sel, in_valid, in_flag;
  logic [3:0]  in_ctrl;
  logic [19:0] in_data;
  logic [19:0] out_data;
  logic        out_dav, out_cav, out_err, out_flag;

  int checks = 0;
  int fails  = 0;
  logic exp_m = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_NS / 2) clk = ~clk;

  sfd_top i_sfd_top (
    .clk(clk), .rst(rst), .wide_sel(wide_sel), .flag_sel(flag_sel),
    .in_valid(in_valid), .in_ctrl(in_ctrl), .in_data(in_data), .in_flag(in_flag),
    .out_data(out_data), .out_dav(out_dav), .out_cav(out_cav),
    .out_err(out_err), .out_flag(out_flag)
  );

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements; updates exp_m.
  task automatic model(input logic v, input logic wd, input logic fs,
                       input logic [3:0] c, input logic [19:0] d, input logic f,
                       output logic [19:0] ed, output logic edav, output logic ecav,
                       output logic eerr, output logic eflag);
    int w, lo, hi, j, kind;
    logic [1:0] ctr;
    logic inv, mm;
    logic [19:0] fld;
    ed = '0; edav = 0; ecav = 0; eerr = 0; eflag = 0;
    if (!v) return;
    w  = wd ? 20 : 16;
    lo = w / 2 - 1;
    hi = w / 2;
    ctr = {d[hi], d[lo]};
    kind = 3; inv = 0;
    if (c == 4'b0011) kind = 1;
    else if (c == 4'b1100) begin kind = 1; inv = 1; end
    else if (c == 4'b0101 && ctr == 2'b10) kind = 2;
    else if (c == 4'b0101 && ctr == 2'b01) kind = 0;
    else if (c == 4'b1010 && ctr == 2'b01) begin kind = 2; inv = 1; end
    else if (c == 4'b1010 && ctr == 2'b10) kind = 0;
    fld = '0;
    for (int i = 0; i < w; i++) fld[i] = d[i] ^ inv;
    if (kind == 1) begin
      ed = fld; edav = 1;
    end else if (kind == 2) begin
      ecav = 1; j = 0;
      for (int i = 0; i < w; i++)
        if (i != lo && i != hi) begin ed[j] = fld[i]; j++; end
    end
    mm = 0;
    if (!fs && kind == 1) begin
      mm = (f != exp_m);
      exp_m = ~f;
    end
    if (fs) begin eerr = (kind == 3); eflag = f; end
    else begin eerr = (kind == 3) || mm; eflag = (kind == 1) ? f : 1'b0; end
  endtask

  task automatic step(input logic v, input logic wd, input logic fs,
                      input logic [3:0] c, input logic [19:0] d, input logic f);
    logic [19:0] ed;
    logic edav, ecav, eerr, eflag;
    in_valid = v; wide_sel = wd; flag_sel = fs; in_ctrl = c; in_data = d; in_flag = f;
    model(v, wd, fs, c, d, f, ed, edav, ecav, eerr, eflag);
    @(negedge clk);
    chk(v ? "R1/R3/R4/R5 data" : "R10 idle data", out_data, ed);
    chk(v ? "R1/R2 dav" : "R10 idle dav", {19'd0, out_dav}, {19'd0, edav});
    chk(v ? "R1/R2 cav" : "R10 idle cav", {19'd0, out_cav}, {19'd0, ecav});
    chk(fs ? "R6/R7 err" : "R6/R9 err", {19'd0, out_err}, {19'd0, eerr});
    chk(fs ? "R7 flag" : "R8 flag", {19'd0, out_flag}, {19'd0, eflag});
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [19:0] d;
    logic f;
    rst = 1; in_valid = 1; wide_sel = 1; flag_sel = 0;
    in_ctrl = 4'b0011; in_data = 20'hFFFFF; in_flag = 1;
    repeat (3) @(negedge clk);
    // R11: reset clears outputs even with a valid frame presented
    chk("R11 reset data", out_data, 20'h0);
    chk("R11 reset strobes", {18'd0, out_dav, out_cav}, 20'h0);
    chk("R11 reset err/flag", {18'd0, out_err, out_flag}, 20'h0);
    rst = 0;

    for (int wd = 1; wd >= 0; wd--)
      for (int fs = 0; fs < 2; fs++)
        for (int c = 0; c < 16; c++)
          for (int ctr = 0; ctr < 4; ctr++)
            for (int k = 0; k < 3; k++) begin
              seed = nxt(seed);
              d = seed[27:8];
              if (wd == 1) begin d[10] = ctr[1]; d[9] = ctr[0]; end
              else begin d[8] = ctr[1]; d[7] = ctr[0]; end
              f = exp_m ^ (((c + ctr + k) % 5) == 0);
              if (fs == 1) f = seed[3];
              step(1'b1, wd[0], fs[0], c[3:0], d, f);
              if (k == 2) begin
                // R10: idle frame with a data code must not touch tracking
                seed = nxt(seed);
                step(1'b0, wd[0], fs[0], 4'b0011, seed[31:12], seed[0]);
              end
            end

    // R11: mid-run reset clears tracked flag value
    in_valid = 1; in_ctrl = 4'b0011; in_flag = 0; flag_sel = 0;
    step(1'b1, 1'b1, 1'b0, 4'b0011, 20'h12345, 1'b0);
    rst = 1;
    @(negedge clk);
    chk("R11 mid reset dav", {19'd0, out_dav}, 20'h0);
    rst = 0;
    exp_m = 1'b0;
    step(1'b1, 1'b1, 1'b0, 4'b0011, 20'hABCDE, 1'b0);
    step(1'b1, 1'b0, 1'b0, 4'b1100, 20'hF0F0F, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule